// File: doc/BRIEF.md
# Bank Precharge Timing Guard

This block watches the command stream sent to a four-bank DDR2-style memory. For every bank it works out the first clock cycle in which a precharge to that bank may legally be issued. It also works out when a precharge-all may be issued. Reads and writes push that earliest cycle later. Precharges and precharge-alls start a per-bank precharge period of tRP clocks, and the block reports when that period has ended.

Commands enter on a valid/ready channel, one command per cycle. A command is accepted in a cycle where both `cmd_valid` and `cmd_ready` are high. The guard pulls `cmd_ready` low only when it must hold back a command: a single-bank precharge whose bank is still inside its read or write recovery window, or a precharge-all while any bank is. Reads, writes and NOPs are never held back. A held command stays on the channel unchanged until it is accepted.

All timing settings are clock-cycle counts. The block copies them only while `rst_n` is low. It then derives three recovery delays from them:
- read delay: AL + BL/2 + max(RTP,2) - 2
- write delay: WL + BL/2 + tWR
- write-with-auto-precharge delay: WL + BL/2 + WR

Top module: `pchg_guard`

## Requirements
- R1: If a read (op code 1) or a read with auto-precharge (op code 2) to bank b is accepted in cycle T, then `pre_ok[b]` is low in cycle T+D-1 and high in cycle T+D, where D = AL + BL/2 + max(RTP,2) - 2. RTP values below 2 count as 2.
- R2: If a write (op code 3) to bank b is accepted in cycle T, then `pre_ok[b]` is high again first in cycle T+WL+BL/2+tWR.
- R3: If a write with auto-precharge (op code 4) to bank b is accepted in cycle T, then `pre_ok[b]` is high again first in cycle T+WL+BL/2+WR. The WR setting is used, not tWR.
- R4: A newly accepted read or write never brings a bank's allowed cycle earlier than a window that is already pending. The later of the two deadlines wins.
- R5: `prea_ok` is high exactly when all four `pre_ok` bits are high.
- R6: When `cmd_valid` is high, `cmd_ready` follows these rules:
  - With a precharge (op code 5) to bank b, `cmd_ready` is low while `pre_ok[b]` is low.
  - With a precharge-all (op code 6), `cmd_ready` is low while `prea_ok` is low.
  - In every other case `cmd_ready` is high.
  - Two precharges may be accepted in consecutive cycles.
- R7: If a precharge to bank b, or a precharge-all, is accepted in cycle T, then `pchg_idle` of each affected bank is low from T+1 to T+tRP-1 and high from T+tRP. A later precharge restarts the period from its own cycle.
- R8: Timing settings are captured only while `rst_n` is low. Changes on the `cfg_*` pins after reset has been released have no effect.
- R9: After reset, all `pre_ok` bits, `prea_ok`, all `pchg_idle` bits and `cmd_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; timing settings are captured while it is low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command may be accepted this cycle |
| cmd_op | input | 3 | Command code: 0 none, 1 read, 2 read+AP, 3 write, 4 write+AP, 5 precharge, 6 precharge-all |
| cmd_bank | input | BA_W | Target bank |
| cfg_al | input | CFG_W | Additive latency, clocks |
| cfg_bl | input | CFG_W | Burst length in beats (4 or 8) |
| cfg_wl | input | CFG_W | Write latency, clocks |
| cfg_rtp | input | CFG_W | Read-to-precharge time, clocks (rounded up) |
| cfg_twr | input | CFG_W | Write recovery for plain writes, clocks |
| cfg_wr | input | CFG_W | Write recovery setting for auto-precharge writes, clocks |
| cfg_trp | input | CFG_W | Precharge period, clocks |
| pre_ok | output | NB | Per-bank precharge allowed |
| prea_ok | output | 1 | Precharge-all allowed |
| pchg_idle | output | NB | Per-bank precharge period complete |

## Verification
Each recovery window is probed in the cycle before it should open and in the cycle it opens. This catches an off-by-one error, a missing -2 offset or a use of tWR in place of WR. A second reset uses an RTP below 2 and a burst of 8, which exposes a design that skips the max(RTP,2) floor or hard-codes the burst size. The bench issues a long write followed at once by a short read to the same bank. A design that overwrites the counter instead of keeping the later deadline would open early. Back-to-back precharges to one bank check that the precharge period restarts. The bench also changes the settings after reset, which shows whether the design keeps listening to its configuration pins.

// File: rtl/pchg_guard_pkg.sv
package pchg_guard_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_RD   = 3'd1,
    OP_RDA  = 3'd2,
    OP_WR   = 3'd3,
    OP_WRA  = 3'd4,
    OP_PRE  = 3'd5,
    OP_PREA = 3'd6
  } op_e;
endpackage

// File: rtl/pchg_cfg_capture.sv
module pchg_cfg_capture #(
  parameter int CFG_W = 5,
  parameter int CNT_W = CFG_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_al,
  input  logic [CFG_W-1:0] cfg_bl,
  input  logic [CFG_W-1:0] cfg_wl,
  input  logic [CFG_W-1:0] cfg_rtp,
  input  logic [CFG_W-1:0] cfg_twr,
  input  logic [CFG_W-1:0] cfg_wr,
  input  logic [CFG_W-1:0] cfg_trp,
  output logic [CNT_W-1:0] rd_dly,
  output logic [CNT_W-1:0] wr_dly,
  output logic [CNT_W-1:0] wra_dly,
  output logic [CNT_W-1:0] trp_dly
);
  logic [CNT_W-1:0] rtp_eff;
  logic [CNT_W-1:0] half_bl;
  logic [CNT_W-1:0] rd_n, wr_n, wra_n;

  always_comb begin
    rtp_eff = (cfg_rtp < CFG_W'(2)) ? CNT_W'(2) : CNT_W'(cfg_rtp);
    half_bl = CNT_W'(cfg_bl >> 1);
    rd_n    = CNT_W'(cfg_al) + half_bl + rtp_eff - CNT_W'(2);
    wr_n    = CNT_W'(cfg_wl) + half_bl + CNT_W'(cfg_twr);
    wra_n   = CNT_W'(cfg_wl) + half_bl + CNT_W'(cfg_wr);
  end

  // Settings are copied only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_dly  <= rd_n;
      wr_dly  <= wr_n;
      wra_dly <= wra_n;
      trp_dly <= CNT_W'(cfg_trp);
    end
  end

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(rd_dly) && $stable(wr_dly) && $stable(wra_dly) && $stable(trp_dly)));
endmodule

// File: rtl/pchg_bank_timer.sv
module pchg_bank_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_hit,
  input  logic             wr_hit,
  input  logic             wra_hit,
  input  logic             pre_hit,
  input  logic [CNT_W-1:0] rd_dly,
  input  logic [CNT_W-1:0] wr_dly,
  input  logic [CNT_W-1:0] wra_dly,
  input  logic [CNT_W-1:0] trp_dly,
  output logic             pre_ok_o,
  output logic             idle_o
);
  logic [CNT_W-1:0] guard_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] guard_dec;
  logic [CNT_W-1:0] sel_dly;
  logic [CNT_W-1:0] load_val;
  logic             load;

  always_comb begin
    load      = rd_hit | wr_hit | wra_hit;
    guard_dec = (guard_q != '0) ? guard_q - 1'b1 : '0;
    if (wra_hit)     sel_dly = wra_dly;
    else if (wr_hit) sel_dly = wr_dly;
    else             sel_dly = rd_dly;
    load_val  = (sel_dly != '0) ? sel_dly - 1'b1 : '0;
  end

  // Recovery window: keep whichever deadline lies later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    guard_q <= '0;
    else if (load) guard_q <= (guard_dec > load_val) ? guard_dec : load_val;
    else           guard_q <= guard_dec;
  end

  // Precharge period: always restarts from the latest precharge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               period_q <= '0;
    else if (pre_hit)         period_q <= (trp_dly != '0) ? trp_dly - 1'b1 : '0;
    else if (period_q != '0)  period_q <= period_q - 1'b1;
  end

  assign pre_ok_o = (guard_q == '0);
  assign idle_o   = (period_q == '0);

  p_rd_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && rd_dly > CNT_W'(1)) |=> !pre_ok_o);
  p_wr_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_dly > CNT_W'(1)) |=> !pre_ok_o);
  p_wra_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wra_hit && wra_dly > CNT_W'(1)) |=> !pre_ok_o);
  p_keep_later_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && guard_q > CNT_W'(1)) |=> !pre_ok_o);
  p_period_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_hit && trp_dly > CNT_W'(1)) |=> !idle_o);
endmodule

// File: rtl/pchg_guard.sv
module pchg_guard
  import pchg_guard_pkg::*;
#(
  parameter int NB    = 4,
  parameter int CFG_W = 5,
  localparam int BA_W  = (NB > 1) ? $clog2(NB) : 1,
  localparam int CNT_W = CFG_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [BA_W-1:0]  cmd_bank,
  input  logic [CFG_W-1:0] cfg_al,
  input  logic [CFG_W-1:0] cfg_bl,
  input  logic [CFG_W-1:0] cfg_wl,
  input  logic [CFG_W-1:0] cfg_rtp,
  input  logic [CFG_W-1:0] cfg_twr,
  input  logic [CFG_W-1:0] cfg_wr,
  input  logic [CFG_W-1:0] cfg_trp,
  output logic [NB-1:0]    pre_ok,
  output logic             prea_ok,
  output logic [NB-1:0]    pchg_idle
);
  op_e              op;
  logic             accept;
  logic [CNT_W-1:0] rd_dly, wr_dly, wra_dly, trp_dly;
  logic [NB-1:0]    rd_hit, wr_hit, wra_hit, pre_hit;

  assign op = op_e'(cmd_op);

  pchg_cfg_capture #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_al(cfg_al), .cfg_bl(cfg_bl), .cfg_wl(cfg_wl), .cfg_rtp(cfg_rtp),
    .cfg_twr(cfg_twr), .cfg_wr(cfg_wr), .cfg_trp(cfg_trp),
    .rd_dly(rd_dly), .wr_dly(wr_dly), .wra_dly(wra_dly), .trp_dly(trp_dly)
  );

  always_comb begin
    prea_ok = &pre_ok;
    unique case (op)
      OP_PRE:  cmd_ready = pre_ok[cmd_bank];
      OP_PREA: cmd_ready = prea_ok;
      default: cmd_ready = 1'b1;
    endcase
  end

  assign accept = cmd_valid & cmd_ready;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic sel;
    assign sel        = accept && (cmd_bank == BA_W'(b));
    assign rd_hit[b]  = sel && (op == OP_RD || op == OP_RDA);
    assign wr_hit[b]  = sel && (op == OP_WR);
    assign wra_hit[b] = sel && (op == OP_WRA);
    assign pre_hit[b] = (sel && op == OP_PRE) || (accept && op == OP_PREA);

    pchg_bank_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .rd_hit(rd_hit[b]), .wr_hit(wr_hit[b]), .wra_hit(wra_hit[b]), .pre_hit(pre_hit[b]),
      .rd_dly(rd_dly), .wr_dly(wr_dly), .wra_dly(wra_dly), .trp_dly(trp_dly),
      .pre_ok_o(pre_ok[b]), .idle_o(pchg_idle[b])
    );
  end

  p_pre_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_PRE && !pre_ok[cmd_bank]) |-> !cmd_ready);
  p_prea_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_PREA && !(&pre_ok)) |-> !cmd_ready);
  p_rw_never_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op != OP_PRE && op != OP_PREA) |-> cmd_ready);
endmodule

// File: tb/sim_pchg_guard.sv
module sim_pchg_guard;
  localparam int CLK_P = 10;
  localparam int NB = 4;
  localparam int CFG_W = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic cmd_valid = 0;
  logic cmd_ready;
  logic [2:0] cmd_op = 0;
  logic [1:0] cmd_bank = 0;
  logic [CFG_W-1:0] cfg_al, cfg_bl, cfg_wl, cfg_rtp, cfg_twr, cfg_wr, cfg_trp;
  logic [NB-1:0] pre_ok, pchg_idle;
  logic prea_ok;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {int cyc; int kind; int bank; bit exp; string req;} exp_t;
  exp_t sbq[$];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pchg_guard #(.NB(NB), .CFG_W(CFG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cfg_al(cfg_al), .cfg_bl(cfg_bl), .cfg_wl(cfg_wl), .cfg_rtp(cfg_rtp),
    .cfg_twr(cfg_twr), .cfg_wr(cfg_wr), .cfg_trp(cfg_trp),
    .pre_ok(pre_ok), .prea_ok(prea_ok), .pchg_idle(pchg_idle)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic expect_at(input int c, input int k, input int b, input bit e, input string r);
    exp_t it;
    it.cyc = c; it.kind = k; it.bank = b; it.exp = e; it.req = r;
    sbq.push_back(it);
  endtask

  // Monitor: pop scoreboard items due this cycle (kind 0 pre_ok, 1 prea_ok, 2 pchg_idle).
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = sbq.size() - 1; i >= 0; i--) begin
        if (sbq[i].cyc == cyc) begin
          logic a;
          case (sbq[i].kind)
            0: a = pre_ok[sbq[i].bank];
            1: a = prea_ok;
            default: a = pchg_idle[sbq[i].bank];
          endcase
          check(a, sbq[i].exp, sbq[i].req, "scoreboard");
          sbq.delete(i);
        end
      end
    end
  end

  task automatic send(input logic [2:0] op, input int b, input bit exp_rdy,
                      input string req, output int t);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_bank = 2'(b);
    #1;
    check(cmd_ready, exp_rdy, req, "cmd_ready");
    t = cyc;
    @(posedge clk);
    #1 cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic do_reset(input int al, bl, wl, rtp, twr, wr, trp);
    rst_n = 0;
    cfg_al = CFG_W'(al); cfg_bl = CFG_W'(bl); cfg_wl = CFG_W'(wl); cfg_rtp = CFG_W'(rtp);
    cfg_twr = CFG_W'(twr); cfg_wr = CFG_W'(wr); cfg_trp = CFG_W'(trp);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
  endtask

  function automatic int rd_d(int al, bl, rtp);
    return al + bl/2 + ((rtp < 2) ? 2 : rtp) - 2;
  endfunction

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int t, t2, ta, tb, tc, d_rd, d_wr, d_wra;
    do_reset(2, 4, 3, 3, 4, 5, 3);
    d_rd  = rd_d(2, 4, 3);
    d_wr  = 3 + 2 + 4;
    d_wra = 3 + 2 + 5;

    // R9 reset state
    @(negedge clk);
    check(&pre_ok, 1'b1, "R9", "pre_ok all");
    check(prea_ok, 1'b1, "R9", "prea_ok");
    check(&pchg_idle, 1'b1, "R9", "pchg_idle all");
    check(cmd_ready, 1'b1, "R9", "cmd_ready");

    // R8: disturb settings after reset; the old ones must still apply
    cfg_al = 7; cfg_rtp = 9; cfg_wl = 8; cfg_twr = 9; cfg_wr = 1; cfg_trp = 9; cfg_bl = 8;

    // R1 read, with R5 all-bank flag
    send(3'd1, 0, 1'b1, "R1", t);
    expect_at(t + d_rd - 1, 0, 0, 1'b0, "R1/R8");
    expect_at(t + d_rd,     0, 0, 1'b1, "R1/R8");
    expect_at(t + d_rd - 1, 1, 0, 1'b0, "R5");
    expect_at(t + d_rd,     1, 0, 1'b1, "R5");
    drain();

    // R1 read with auto-precharge
    send(3'd2, 1, 1'b1, "R1", t);
    expect_at(t + d_rd - 1, 0, 1, 1'b0, "R1");
    expect_at(t + d_rd,     0, 1, 1'b1, "R1");
    drain();

    // R2 write, R6 back-pressure, R7 precharge period on another bank
    send(3'd3, 2, 1'b1, "R2", t);
    expect_at(t + d_wr - 1, 0, 2, 1'b0, "R2");
    expect_at(t + d_wr,     0, 2, 1'b1, "R2");
    send(3'd5, 2, 1'b0, "R6", t2);
    send(3'd6, 0, 1'b0, "R6", t2);
    send(3'd5, 3, 1'b1, "R6", ta);
    expect_at(ta + 2, 2, 3, 1'b0, "R7");
    expect_at(ta + 3, 2, 3, 1'b1, "R7");
    drain();

    // R3 write with auto-precharge uses WR
    send(3'd4, 3, 1'b1, "R3", t);
    expect_at(t + d_wra - 1, 0, 3, 1'b0, "R3");
    expect_at(t + d_wra,     0, 3, 1'b1, "R3");
    drain();

    // R4 later deadline kept
    send(3'd3, 0, 1'b1, "R4", t);
    send(3'd1, 0, 1'b1, "R4", t2);
    expect_at(t2 + d_rd,    0, 0, 1'b0, "R4");
    expect_at(t + d_wr - 1, 0, 0, 1'b0, "R4");
    expect_at(t + d_wr,     0, 0, 1'b1, "R4");
    drain();

    // R7 restart with back-to-back precharges (R6), then precharge-all
    send(3'd5, 1, 1'b1, "R6", ta);
    send(3'd5, 1, 1'b1, "R6", tb);
    expect_at(ta + 3, 2, 1, 1'b0, "R7");
    expect_at(tb + 3, 2, 1, 1'b1, "R7");
    drain();
    send(3'd6, 0, 1'b1, "R6", tc);
    for (int b = 0; b < NB; b++) begin
      expect_at(tc + 2, 2, b, 1'b0, "R7");
      expect_at(tc + 3, 2, b, 1'b1, "R7");
    end
    drain();

    // R1 second setting: RTP below 2 and burst of 8
    do_reset(0, 8, 2, 1, 3, 3, 2);
    d_rd = rd_d(0, 8, 1);
    send(3'd1, 2, 1'b1, "R1", t);
    expect_at(t + d_rd - 1, 0, 2, 1'b0, "R1");
    expect_at(t + d_rd,     0, 2, 1'b1, "R1");
    drain();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule